// File: doc/BRIEF.md
# Command Descriptor Responder

This block sits behind the selection stage of a storage-bus target. After a select-with-attention operation, the host's command bytes arrive one per cycle on a simple valid/data stream. The first byte is a message byte, and the command descriptor starts at the second byte. A start pulse closes the command. The block then decodes the target number and the opcode and produces a result set:

- status, interrupt and sequence codes;
- a data-phase transfer size and direction;
- the logical block address, for read and write commands;
- a short response payload, read one byte at a time through an indexed port.

The following come in as ports: the per-target presence flags, the per-target "optical-type device" flags and the medium's sector count. No storage is attached. Read and write commands report only the size and direction of their data phase. The interrupt line rises with the done pulse and stays high until the next start.

Top module: `cmd_desc_responder`

## Requirements
- R1: After reset, done and irq are 0; status, intr, seq, xferSize, blockAddr and respLen are 0; xferDirIn is 0.
- R2: A start sampled at clock edge k gives done = 1 for exactly one cycle, from edge k+2. All result outputs are valid while done = 1 and hold until the next start.
- R3: If selTarget is greater than 4, or its devPresent bit is 0, the result is status 0x80, intr 0x20 and seq 0x00, with xferSize 0, respLen 0 and xferDirIn 0. This applies whatever the opcode.
- R4: For a present target, the result is status 0x91, intr 0x18 and seq 0x04. irq rises together with done and stays at 1 until the next start clears it.
- R5: Opcode 0x12 (byte 1 of the stream) gives respLen 36 and xferDirIn 1. Response byte 0 is 5 if the target's devIsCd bit is set, and 0 otherwise. Byte 2 is 1, byte 3 is 2, and all other bytes are 0.
- R6: Opcode 0x25 gives respLen 8 and xferDirIn 1. Response bytes 0 to 3 are sectorCount, most significant byte first. Bytes 4 to 7 are 0, 0, 2, 0.
- R7: Opcode 0x28 gives xferDirIn 1. blockAddr is taken from stream bytes 3 to 6, most significant first. xferSize is the 16-bit count in stream bytes 8 (high) and 9 (low), times 512.
- R8: Opcode 0x2A gives the same blockAddr and xferSize as R7, with xferDirIn 0.
- R9: Opcodes 0x00, 0x1A and any opcode not listed above give xferSize 0, xferDirIn 0, respLen 0 and blockAddr 0.
- R10: Stream byte positions not received before start are decoded as 0. Bytes beyond the twelfth are dropped.
- R11: rdData is 0 for every rdIdx at or above respLen.
- R12: On the edge that samples start, xferSize, xferDirIn, respLen and blockAddr return to 0 and irq falls. This happens before any decoding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Command byte valid |
| inData | input | 8 | Command byte |
| start | input | 1 | Closes the command and starts the decode |
| selTarget | input | 3 | Target number, the low bits of the select register |
| devPresent | input | 8 | Per-target device-present flags |
| devIsCd | input | 8 | Per-target optical-type flags |
| sectorCount | input | 32 | Sector count reported by the capacity command |
| rdIdx | input | 6 | Response byte index |
| rdData | output | 8 | Response byte at rdIdx |
| done | output | 1 | One-cycle pulse: results valid |
| irq | output | 1 | Interrupt, cleared by start |
| status | output | 8 | Status code |
| intr | output | 8 | Interrupt cause code |
| seq | output | 8 | Sequence step code |
| xferSize | output | 25 | Data-phase byte count |
| xferDirIn | output | 1 | 1 = device to host |
| blockAddr | output | 32 | Logical block address for read/write |
| respLen | output | 6 | Valid response bytes |

## Verification
The assertions assume that start arrives only while the block is idle, and that start never coincides with a byte on the stream. They also assume that selTarget, devPresent, devIsCd and sectorCount stay steady between start and done. The stimulus meets all of these because it is strictly sequential: one task sends the bytes, drops inValid, pulses start, and changes the configuration inputs only after done has been observed. The sweep covers every target number against two complementary presence patterns and every listed opcode plus an unknown one. It also sends short and over-long commands.

// File: rtl/cdr_pkg.sv
package cdr_pkg;
  localparam logic [7:0] OP_TEST_READY = 8'h00;
  localparam logic [7:0] OP_INQUIRY    = 8'h12;
  localparam logic [7:0] OP_MODE_SENSE = 8'h1A;
  localparam logic [7:0] OP_READ_CAP   = 8'h25;
  localparam logic [7:0] OP_READ10     = 8'h28;
  localparam logic [7:0] OP_WRITE10    = 8'h2A;

  localparam logic [7:0] ST_IRQ  = 8'h80;
  localparam logic [7:0] ST_TC   = 8'h10;
  localparam logic [7:0] ST_DIN  = 8'h01;
  localparam logic [7:0] IC_FUNC = 8'h08;
  localparam logic [7:0] IC_SERV = 8'h10;
  localparam logic [7:0] IC_DISC = 8'h20;
  localparam logic [7:0] SQ_IDLE = 8'h00;
  localparam logic [7:0] SQ_CMD  = 8'h04;

  typedef enum logic [1:0] {RK_NONE, RK_INQ, RK_CAP} respKind_t;

  typedef struct packed {
    logic take;   // store one stream byte
    logic latch;  // close command, clear transfer report
    logic load;   // register decoded results
  } cdrStrobes_t;
endpackage

// File: rtl/cdr_control.sv
module cdr_control
  import cdr_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        inValid,
  input  logic        start,
  output cdrStrobes_t stb,
  output logic        done,
  output logic        irq
);
  typedef enum logic {S_IDLE, S_DECODE} state_t;
  state_t state;

  always_comb begin
    stb.take  = inValid && !start && (state == S_IDLE);
    stb.latch = start && (state == S_IDLE);
    stb.load  = (state == S_DECODE);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= S_IDLE;
      done  <= 1'b0;
      irq   <= 1'b0;
    end else begin
      done <= stb.load;
      if (stb.latch) begin
        state <= S_DECODE;
        irq   <= 1'b0;
      end else if (stb.load) begin
        state <= S_IDLE;
        irq   <= 1'b1;
      end
    end
  end

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done); // R2
  AST_IRQ_WITH_DONE: assert property (@(posedge clk) disable iff (!rstN)
    done |-> irq); // R4
  AST_IRQ_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (irq && !start) |=> irq); // R4
endmodule

// File: rtl/cdr_datapath.sv
module cdr_datapath
  import cdr_pkg::*;
#(
  parameter int CMD_DEPTH = 12,
  parameter int NUM_TGT   = 8,
  parameter int MAX_TGT   = 4,
  parameter int CNT_W     = 16,
  parameter int BLK_SHIFT = 9,
  parameter int RESP_AW   = 6,
  localparam int TGT_W    = $clog2(NUM_TGT),
  localparam int IDX_W    = $clog2(CMD_DEPTH + 1),
  localparam int XFER_W   = CNT_W + BLK_SHIFT
)(
  input  logic                clk,
  input  logic                rstN,
  input  cdrStrobes_t         stb,
  input  logic [7:0]          inData,
  input  logic [TGT_W-1:0]    selTarget,
  input  logic [NUM_TGT-1:0]  devPresent,
  input  logic [NUM_TGT-1:0]  devIsCd,
  input  logic [31:0]         sectorCount,
  input  logic [RESP_AW-1:0]  rdIdx,
  output logic [7:0]          rdData,
  output logic [7:0]          status,
  output logic [7:0]          intr,
  output logic [7:0]          seq,
  output logic [XFER_W-1:0]   xferSize,
  output logic                xferDirIn,
  output logic [31:0]         blockAddr,
  output logic [RESP_AW-1:0]  respLen
);
  localparam logic [31:0] BLK_BYTES = 32'd1 << BLK_SHIFT;
  localparam int INQ_LEN = 36;
  localparam int CAP_LEN = 8;

  logic [7:0]       cmdBuf [CMD_DEPTH];
  logic [7:0]       cmdByte[CMD_DEPTH];
  logic [IDX_W-1:0] wrIdx, rxCount;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrIdx   <= '0;
      rxCount <= '0;
      for (int i = 0; i < CMD_DEPTH; i++) cmdBuf[i] <= '0;
    end else if (stb.latch) begin
      rxCount <= wrIdx;
      wrIdx   <= '0;
    end else if (stb.take && (wrIdx < IDX_W'(CMD_DEPTH))) begin
      cmdBuf[wrIdx] <= inData;
      wrIdx         <= wrIdx + 1'b1;
    end
  end

  for (genvar g = 0; g < CMD_DEPTH; g++) begin : g_mask
    assign cmdByte[g] = (IDX_W'(g) < rxCount) ? cmdBuf[g] : 8'h00;
  end

  logic              missing;
  logic [7:0]        opcode;
  logic [31:0]       lbaField;
  logic [CNT_W-1:0]  cntField;
  assign missing  = (int'(selTarget) > MAX_TGT) || !devPresent[selTarget];
  assign opcode   = cmdByte[1];
  assign lbaField = {cmdByte[3], cmdByte[4], cmdByte[5], cmdByte[6]};
  assign cntField = CNT_W'({cmdByte[8], cmdByte[9]});

  respKind_t   kindQ;
  logic        isCdQ;
  logic [31:0] sectQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      status <= '0; intr <= '0; seq <= '0;
      xferSize <= '0; xferDirIn <= 1'b0; blockAddr <= '0;
      kindQ <= RK_NONE; isCdQ <= 1'b0; sectQ <= '0;
    end else if (stb.latch) begin
      xferSize  <= '0;
      xferDirIn <= 1'b0;
      blockAddr <= '0;
      kindQ     <= RK_NONE;
    end else if (stb.load) begin
      isCdQ <= devIsCd[selTarget];
      sectQ <= sectorCount;
      if (missing) begin
        status <= ST_IRQ;
        intr   <= IC_DISC;
        seq    <= SQ_IDLE;
      end else begin
        status <= ST_IRQ | ST_TC | ST_DIN;
        intr   <= IC_SERV | IC_FUNC;
        seq    <= SQ_CMD;
        case (opcode)
          OP_INQUIRY: begin
            kindQ <= RK_INQ; xferDirIn <= 1'b1;
          end
          OP_READ_CAP: begin
            kindQ <= RK_CAP; xferDirIn <= 1'b1;
          end
          OP_READ10: begin
            blockAddr <= lbaField;
            xferSize  <= XFER_W'(cntField) << BLK_SHIFT;
            xferDirIn <= 1'b1;
          end
          OP_WRITE10: begin
            blockAddr <= lbaField;
            xferSize  <= XFER_W'(cntField) << BLK_SHIFT;
            xferDirIn <= 1'b0;
          end
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    case (kindQ)
      RK_INQ:  respLen = RESP_AW'(INQ_LEN);
      RK_CAP:  respLen = RESP_AW'(CAP_LEN);
      default: respLen = '0;
    endcase
  end

  always_comb begin
    rdData = 8'h00;
    if (kindQ == RK_INQ) begin
      case (rdIdx)
        RESP_AW'(0): rdData = isCdQ ? 8'h05 : 8'h00;
        RESP_AW'(2): rdData = 8'h01;
        RESP_AW'(3): rdData = 8'h02;
        default:     rdData = 8'h00;
      endcase
    end else if (kindQ == RK_CAP) begin
      case (rdIdx)
        RESP_AW'(0): rdData = sectQ[31:24];
        RESP_AW'(1): rdData = sectQ[23:16];
        RESP_AW'(2): rdData = sectQ[15:8];
        RESP_AW'(3): rdData = sectQ[7:0];
        RESP_AW'(4): rdData = BLK_BYTES[31:24];
        RESP_AW'(5): rdData = BLK_BYTES[23:16];
        RESP_AW'(6): rdData = BLK_BYTES[15:8];
        RESP_AW'(7): rdData = BLK_BYTES[7:0];
        default:     rdData = 8'h00;
      endcase
    end
  end

  AST_MISSING_CODES: assert property (@(posedge clk) disable iff (!rstN)
    (stb.load && missing) |=> (status == 8'h80 && intr == 8'h20 && seq == 8'h00 && xferSize == '0)); // R3
  AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    stb.latch |=> (xferSize == '0 && !xferDirIn && respLen == '0)); // R12
  AST_RESP_DIR_IN: assert property (@(posedge clk) disable iff (!rstN)
    (respLen != '0) |-> xferDirIn); // R5
  AST_SIZE_ALIGNED: assert property (@(posedge clk) disable iff (!rstN)
    xferSize[BLK_SHIFT-1:0] == '0); // R7
  AST_SIZE_NEEDS_OK: assert property (@(posedge clk) disable iff (!rstN)
    (xferSize != '0) |-> (status == 8'h91)); // R4
endmodule

// File: rtl/cmd_desc_responder.sv
module cmd_desc_responder
  import cdr_pkg::*;
#(
  parameter int CMD_DEPTH = 12,
  parameter int NUM_TGT   = 8,
  parameter int MAX_TGT   = 4,
  parameter int CNT_W     = 16,
  parameter int BLK_SHIFT = 9,
  parameter int RESP_AW   = 6,
  localparam int TGT_W    = $clog2(NUM_TGT),
  localparam int XFER_W   = CNT_W + BLK_SHIFT
)(
  input  logic               clk,
  input  logic               rstN,
  input  logic               inValid,
  input  logic [7:0]         inData,
  input  logic               start,
  input  logic [TGT_W-1:0]   selTarget,
  input  logic [NUM_TGT-1:0] devPresent,
  input  logic [NUM_TGT-1:0] devIsCd,
  input  logic [31:0]        sectorCount,
  input  logic [RESP_AW-1:0] rdIdx,
  output logic [7:0]         rdData,
  output logic               done,
  output logic               irq,
  output logic [7:0]         status,
  output logic [7:0]         intr,
  output logic [7:0]         seq,
  output logic [XFER_W-1:0]  xferSize,
  output logic               xferDirIn,
  output logic [31:0]        blockAddr,
  output logic [RESP_AW-1:0] respLen
);
  cdrStrobes_t stb;

  cdr_control u_ctrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .start(start),
    .stb(stb), .done(done), .irq(irq)
  );

  cdr_datapath #(
    .CMD_DEPTH(CMD_DEPTH), .NUM_TGT(NUM_TGT), .MAX_TGT(MAX_TGT),
    .CNT_W(CNT_W), .BLK_SHIFT(BLK_SHIFT), .RESP_AW(RESP_AW)
  ) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .inData(inData),
    .selTarget(selTarget), .devPresent(devPresent), .devIsCd(devIsCd),
    .sectorCount(sectorCount), .rdIdx(rdIdx), .rdData(rdData),
    .status(status), .intr(intr), .seq(seq), .xferSize(xferSize),
    .xferDirIn(xferDirIn), .blockAddr(blockAddr), .respLen(respLen)
  );
endmodule

// File: tb/cmd_desc_responder_tb.sv
module cmd_desc_responder_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic [7:0]  inData = '0;
  logic        start = 1'b0;
  logic [2:0]  selTarget = '0;
  logic [7:0]  devPresent = '0;
  logic [7:0]  devIsCd = '0;
  logic [31:0] sectorCount = '0;
  logic [5:0]  rdIdx = '0;
  logic [7:0]  rdData;
  logic        done, irq, xferDirIn;
  logic [7:0]  status, intr, seq;
  logic [24:0] xferSize;
  logic [31:0] blockAddr;
  logic [5:0]  respLen;

  int checks = 0;
  int errors = 0;
  logic [7:0] cmdB [16];

  always #2.5 clk = ~clk;

  cmd_desc_responder u_dut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inData(inData), .start(start),
    .selTarget(selTarget), .devPresent(devPresent), .devIsCd(devIsCd),
    .sectorCount(sectorCount), .rdIdx(rdIdx), .rdData(rdData), .done(done),
    .irq(irq), .status(status), .intr(intr), .seq(seq), .xferSize(xferSize),
    .xferDirIn(xferDirIn), .blockAddr(blockAddr), .respLen(respLen)
  );

  task automatic chk(input logic ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] eb(input int i, input int n);
    return (i < n && i < 12) ? cmdB[i] : 8'h00;
  endfunction

  // Sends n bytes of cmdB, runs one command, checks every result.
  task automatic runCmd(input int n);
    logic miss, dirE;
    logic [7:0] op, stE, inE, sqE;
    logic [24:0] sizeE;
    logic [31:0] addrE;
    int lenE, kind;
    miss = (selTarget > 3'd4) || !devPresent[selTarget];
    op = eb(1, n);
    sizeE = '0; addrE = '0; dirE = 1'b0; lenE = 0; kind = 0;
    if (miss) begin
      stE = 8'h80; inE = 8'h20; sqE = 8'h00;
    end else begin
      stE = 8'h91; inE = 8'h18; sqE = 8'h04;
      if (op == 8'h12) begin kind = 1; lenE = 36; dirE = 1'b1; end
      else if (op == 8'h25) begin kind = 2; lenE = 8; dirE = 1'b1; end
      else if (op == 8'h28 || op == 8'h2A) begin
        addrE = {eb(3, n), eb(4, n), eb(5, n), eb(6, n)};
        sizeE = 25'({eb(8, n), eb(9, n)}) * 25'd512;
        dirE = (op == 8'h28);
      end
    end
    for (int i = 0; i < n; i++) begin
      @(negedge clk); inValid = 1'b1; inData = cmdB[i];
    end
    @(negedge clk); inValid = 1'b0; start = 1'b1;
    @(negedge clk); start = 1'b0;
    chk(xferSize == '0 && !xferDirIn && respLen == '0 && blockAddr == '0,
        "R12 cleared at start", xferSize, 0);
    chk(!irq && !done, "R4 irq cleared by start", {irq, done}, 0);
    @(negedge clk);
    chk(done && irq, "R2 done pulse / R4 irq", {done, irq}, 3);
    if (miss) begin
      chk(status == stE && intr == inE && seq == sqE, "R3 missing target codes",
          {status, intr, seq}, {stE, inE, sqE});
      chk(xferSize == 0 && respLen == 0 && !xferDirIn, "R3 missing target empty",
          {xferSize, respLen}, 0);
    end else begin
      chk(status == stE && intr == inE && seq == sqE, "R4 completion codes",
          {status, intr, seq}, {stE, inE, sqE});
      chk(xferSize == sizeE && blockAddr == addrE, "R7/R8/R9 size and address",
          {xferSize, blockAddr}, {sizeE, addrE});
      chk(xferDirIn == dirE, "R7/R8/R9 direction", xferDirIn, dirE);
      chk(int'(respLen) == lenE, "R5/R6/R9 response length", respLen, lenE);
    end
    @(negedge clk);
    chk(!done && irq, "R2 single-cycle done, R4 irq held", {done, irq}, 1);
    if (kind != 0) begin
      for (int idx = 0; idx < 40; idx++) begin
        logic [7:0] exp;
        exp = 8'h00;
        if (kind == 1) begin
          if (idx == 0) exp = devIsCd[selTarget] ? 8'h05 : 8'h00;
          if (idx == 2) exp = 8'h01;
          if (idx == 3) exp = 8'h02;
        end else begin
          if (idx < 4) exp = 8'(sectorCount >> (24 - 8 * idx));
          if (idx == 6) exp = 8'h02;
        end
        rdIdx = 6'(idx);
        #1;
        chk(rdData == exp, (idx >= lenE) ? "R11 beyond response" :
            (kind == 1 ? "R5 inquiry byte" : "R6 capacity byte"), rdData, exp);
      end
    end
  endtask

  task automatic fillCmd(input logic [7:0] op, input int seed);
    for (int i = 0; i < 16; i++) cmdB[i] = 8'((seed * 37 + i * 11 + 5) & 255);
    cmdB[0] = 8'h80;
    cmdB[1] = op;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] ops [7];
    ops = '{8'h00, 8'h12, 8'h1A, 8'h25, 8'h28, 8'h2A, 8'h7F};
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk(!done && !irq && status == 0 && intr == 0 && seq == 0 && xferSize == 0 &&
        !xferDirIn && blockAddr == 0 && respLen == 0, "R1 reset state",
        {done, irq, status, intr, seq}, 0);

    // Sweep: every target x two presence patterns x every opcode
    for (int p = 0; p < 2; p++) begin
      for (int t = 0; t < 8; t++) begin
        for (int o = 0; o < 7; o++) begin
          devPresent  = (p == 0) ? 8'b1010_1101 : 8'b0101_0010;
          devIsCd     = 8'b0110_0110;
          sectorCount = 32'h1234_5678 + 32'(t * 977 + o);
          selTarget   = 3'(t);
          fillCmd(ops[o], t * 7 + o + p * 3);
          runCmd(10);
        end
      end
    end

    // R7 R8 boundary counts: zero and maximum block count
    devPresent = 8'hFF; selTarget = 3'd1;
    fillCmd(8'h28, 3); cmdB[8] = 8'h00; cmdB[9] = 8'h00; runCmd(10);
    fillCmd(8'h2A, 4); cmdB[8] = 8'hFF; cmdB[9] = 8'hFF; runCmd(10);
    fillCmd(8'h28, 9); cmdB[8] = 8'h00; cmdB[9] = 8'h01; runCmd(10);

    // R10 short commands and an over-long command
    fillCmd(8'h28, 11); runCmd(7);
    fillCmd(8'h2A, 12); runCmd(5);
    fillCmd(8'h12, 13); runCmd(1);
    fillCmd(8'h28, 14); runCmd(16);

    // R6 capacity extremes, R5 optical flag on the same target
    sectorCount = 32'hFFFF_FFFF; fillCmd(8'h25, 15); runCmd(10);
    sectorCount = 32'h0000_0000; fillCmd(8'h25, 16); runCmd(10);
    devIsCd = 8'h02; fillCmd(8'h12, 17); runCmd(10);
    devIsCd = 8'h00; fillCmd(8'h12, 18); runCmd(10);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule